// File: doc/BRIEF.md
# Masked Event Interrupt Unit

This unit gathers thirteen one-cycle event pulses from the transmit, receive and control paths of an Ethernet MAC. Each pulse sets a sticky bit in a 32-bit event word, at a fixed position in the upper bits 31 down to 19. Software reads the event word through a small register port. It acknowledges events by writing ones to the bits it wants cleared.

A second 32-bit word, the enable mask, is loaded whole by a write. Each event bit ANDed with its mask bit drives one dedicated active-high interrupt line. The lines do not follow bit order; each has a fixed line number. Writing the transmit-control select with bit 0 set raises the graceful-stop-complete event at once, because the transmit path stops immediately.

Top module: `evt_irq_unit`

## Requirements
- R1: A pulse on `src_set[k]` sets event bit 19+k at the next clock edge. The bit positions are: underrun 19, retry limit 20, late collision 21, bus error 22, management done 23, receive buffer 24, receive frame 25, transmit buffer 26, transmit frame 27, graceful stop 28, babbling transmit 29, babbling receive 30, heartbeat 31. A set bit stays set until it is cleared.
- R2: A write with `reg_sel`=0 (event word) clears every event bit that is 1 in `reg_wdata`. All other event bits are left as they were.
- R3: A write with `reg_sel`=1 (mask word) loads all 32 bits of `reg_wdata` into the mask. The mask reads back unchanged.
- R4: `irq_o[n]` equals event AND mask for the bit assigned to line n, one clock after that event or mask value is stored. The bits for lines 0 to 12 are 27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30.
- R5: When `rst_n` is low, the event word, the mask word and all lines are zero.
- R6: A write with `reg_sel`=2 (transmit control) and `reg_wdata[0]`=1 sets event bit 28 at that edge. The same write with bit 0 = 0 changes no event bit. This select reads as zero.
- R7: If a set pulse and a software clear hit the same event bit in one cycle, the bit ends up set.
- R8: Event bits 18 to 0 always read as zero, and no write or pulse can set them.
- R9: `reg_rdata` shows the selected word with no delay: the event word for select 0, the mask for select 1, and zero for selects 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the selected word |
| reg_sel | input | 2 | Word select: 0 event, 1 mask, 2 transmit control |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word |
| src_set | input | 13 | Event set pulses; bit k sets event bit 19+k |
| irq_o | output | 13 | Interrupt lines, active high |

## Verification
Pulses and writes act on the event and mask words at the clock edge where they are applied. The read port is combinational, so the new value can be read back just after that same edge. An interrupt line follows one edge later, because it is registered from the stored words. The bench drives its inputs on the falling edge and then steps its reference model through the rising edge. One time unit after the rising edge it compares the lines and the selected read word against the model. This places every line check exactly one cycle behind the event or mask change that caused it.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

  localparam int unsigned WORD_W   = 32;
  localparam int unsigned SRC_N    = 13;
  localparam int unsigned EVT_BASE = 19;
  localparam int unsigned GSTOP_BIT = 28;

  typedef enum logic [1:0] {
    SEL_EVENT = 2'd0,
    SEL_MASK  = 2'd1,
    SEL_TXCTL = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  // Event-word bit position that feeds interrupt line n.
  function automatic int unsigned line_bit(input int unsigned n);
    case (n)
      0:       line_bit = 27;
      1:       line_bit = 26;
      2:       line_bit = 19;
      3:       line_bit = 20;
      4:       line_bit = 25;
      5:       line_bit = 24;
      6:       line_bit = 23;
      7:       line_bit = 21;
      8:       line_bit = 31;
      9:       line_bit = 28;
      10:      line_bit = 22;
      11:      line_bit = 29;
      default: line_bit = 30;
    endcase
  endfunction

  // Next state of a write-one-to-clear sticky vector; set beats clear.
  function automatic logic [SRC_N-1:0] sticky_next(input logic [SRC_N-1:0] cur,
                                                   input logic [SRC_N-1:0] clr,
                                                   input logic [SRC_N-1:0] set);
    sticky_next = (cur & ~clr) | set;
  endfunction

endpackage

// File: rtl/evt_wr_decode.sv
module evt_wr_decode
  import evt_irq_pkg::*;
#(
  parameter int unsigned SRC_N    = evt_irq_pkg::SRC_N,
  parameter int unsigned EVT_BASE = evt_irq_pkg::EVT_BASE,
  parameter int unsigned GSTOP    = evt_irq_pkg::GSTOP_BIT
) (
  input  logic             reg_wr,
  input  logic [1:0]       reg_sel,
  input  logic [SRC_N-1:0] wr_evt_bits,
  input  logic             wr_ctl_bit,
  input  logic [SRC_N-1:0] src_set,
  output logic [SRC_N-1:0] clr_vec,
  output logic [SRC_N-1:0] set_vec,
  output logic             mask_we
);
  localparam int unsigned GSTOP_REL = GSTOP - EVT_BASE;

  logic             gstop_pulse;
  logic [SRC_N-1:0] gstop_vec;

  always_comb begin
    clr_vec     = '0;
    mask_we     = 1'b0;
    gstop_pulse = 1'b0;
    if (reg_wr) begin
      case (reg_sel_e'(reg_sel))
        SEL_EVENT: clr_vec     = wr_evt_bits;
        SEL_MASK:  mask_we     = 1'b1;
        SEL_TXCTL: gstop_pulse = wr_ctl_bit;
        default:   ;
      endcase
    end
    gstop_vec            = '0;
    gstop_vec[GSTOP_REL] = gstop_pulse;
    set_vec              = src_set | gstop_vec;
  end
endmodule

// File: rtl/evt_store.sv
module evt_store
  import evt_irq_pkg::*;
#(
  parameter int unsigned SRC_N = evt_irq_pkg::SRC_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] clr_vec,
  input  logic [SRC_N-1:0] set_vec,
  output logic [SRC_N-1:0] evt_q
);
  logic [SRC_N-1:0] evt_d;

  always_comb evt_d = sticky_next(evt_q, clr_vec, set_vec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= evt_d;
  end
endmodule

// File: rtl/evt_line_drv.sv
module evt_line_drv
  import evt_irq_pkg::*;
#(
  parameter int unsigned SRC_N    = evt_irq_pkg::SRC_N,
  parameter int unsigned EVT_BASE = evt_irq_pkg::EVT_BASE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] evt_q,
  input  logic [SRC_N-1:0] mask_hi,
  output logic [SRC_N-1:0] line_q
);
  for (genvar n = 0; n < SRC_N; n++) begin : g_line
    localparam int unsigned REL = line_bit(n) - EVT_BASE;
    logic hit;
    assign hit = evt_q[REL] & mask_hi[REL];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_q[n] <= 1'b0;
      else        line_q[n] <= hit;
    end
  end
endmodule

// File: rtl/evt_irq_unit.sv
module evt_irq_unit
  import evt_irq_pkg::*;
#(
  parameter int unsigned WORD_W   = evt_irq_pkg::WORD_W,
  parameter int unsigned SRC_N    = evt_irq_pkg::SRC_N,
  parameter int unsigned EVT_BASE = evt_irq_pkg::EVT_BASE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic [SRC_N-1:0]  src_set,
  output logic [SRC_N-1:0]  irq_o
);
  localparam int unsigned TOP = EVT_BASE + SRC_N - 1;

  logic [SRC_N-1:0]  clr_vec;
  logic [SRC_N-1:0]  set_vec;
  logic              mask_we;
  logic [SRC_N-1:0]  evt_q;
  logic [WORD_W-1:0] mask_q;
  logic [WORD_W-1:0] evt_word;

  evt_wr_decode #(.SRC_N(SRC_N), .EVT_BASE(EVT_BASE)) u_dec (
    .reg_wr      (reg_wr),
    .reg_sel     (reg_sel),
    .wr_evt_bits (reg_wdata[TOP:EVT_BASE]),
    .wr_ctl_bit  (reg_wdata[0]),
    .src_set     (src_set),
    .clr_vec     (clr_vec),
    .set_vec     (set_vec),
    .mask_we     (mask_we)
  );

  evt_store #(.SRC_N(SRC_N)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_vec (clr_vec),
    .set_vec (set_vec),
    .evt_q   (evt_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= reg_wdata;
  end

  always_comb begin
    evt_word               = '0;
    evt_word[TOP:EVT_BASE] = evt_q;
  end

  evt_line_drv #(.SRC_N(SRC_N), .EVT_BASE(EVT_BASE)) u_lines (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_q   (evt_q),
    .mask_hi (mask_q[TOP:EVT_BASE]),
    .line_q  (irq_o)
  );

  always_comb begin
    case (reg_sel_e'(reg_sel))
      SEL_EVENT: reg_rdata = evt_word;
      SEL_MASK:  reg_rdata = mask_q;
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/evt_irq_chk.sv
module evt_irq_chk
  import evt_irq_pkg::*;
#(
  parameter int unsigned WORD_W   = evt_irq_pkg::WORD_W,
  parameter int unsigned SRC_N    = evt_irq_pkg::SRC_N,
  parameter int unsigned EVT_BASE = evt_irq_pkg::EVT_BASE
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [1:0]        reg_sel,
  input logic [WORD_W-1:0] reg_wdata,
  input logic [WORD_W-1:0] reg_rdata,
  input logic [SRC_N-1:0]  src_set,
  input logic [SRC_N-1:0]  irq_o,
  input logic [WORD_W-1:0] evt_word,
  input logic [WORD_W-1:0] mask_q
);
  localparam int unsigned TOP = EVT_BASE + SRC_N - 1;

  assert_set_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((evt_word[TOP:EVT_BASE] & $past(src_set)) == $past(src_set)));

  assert_w1c_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd0 && src_set == '0) |=> ((evt_word & $past(reg_wdata)) == '0));

  assert_mask_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd1) |=> (mask_q == $past(reg_wdata)));

  for (genvar n = 0; n < SRC_N; n++) begin : g_ln
    localparam int unsigned B = line_bit(n);
    assert_line_map_R4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq_o[n] == $past(evt_word[B] & mask_q[B])));
  end

  assert_reset_clear_R5: assert property (@(posedge clk)
    !rst_n |-> (irq_o == '0 && evt_word == '0 && mask_q == '0));

  assert_gstop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd2 && reg_wdata[0]) |=> evt_word[GSTOP_BIT]);

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd0 && (reg_wdata[TOP:EVT_BASE] & src_set) != '0)
      |=> ((evt_word[TOP:EVT_BASE] & $past(reg_wdata[TOP:EVT_BASE] & src_set))
           == $past(reg_wdata[TOP:EVT_BASE] & src_set)));

  assert_low_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == 2'd0) |-> (reg_rdata[EVT_BASE-1:0] == '0));
endmodule

bind evt_irq_unit evt_irq_chk #(.WORD_W(WORD_W), .SRC_N(SRC_N), .EVT_BASE(EVT_BASE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_sel   (reg_sel),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .src_set   (src_set),
  .irq_o     (irq_o),
  .evt_word  (evt_word),
  .mask_q    (mask_q)
);

// File: tb/sim_evt_irq_unit.sv
`timescale 1ns/1ps
module sim_evt_irq_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [12:0] src_set = '0;
  logic [12:0] irq_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // Reference state
  logic [31:0] m_evt = '0;
  logic [31:0] m_mask = '0;
  logic [12:0] m_line = '0;
  int line_src[13] = '{27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30};

  always #5 clk = ~clk;

  evt_irq_unit u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_set(src_set), .irq_o(irq_o)
  );

  task automatic check(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, got, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [1:0] s);
    if (s == 2'd0) return m_evt;
    if (s == 2'd1) return m_mask;
    return 32'h0;
  endfunction

  // One clock: drive at falling edge, advance model over rising edge, compare after it.
  task automatic step(input logic wr, input logic [1:0] s, input logic [31:0] d,
                      input logic [12:0] set, input string tag);
    logic [12:0] nl;
    @(negedge clk);
    reg_wr = wr; reg_sel = s; reg_wdata = d; src_set = set;
    for (int n = 0; n < 13; n++) nl[n] = m_evt[line_src[n]] & m_mask[line_src[n]];
    @(posedge clk);
    #1;
    m_line = nl;
    if (wr && s == 2'd0) m_evt = m_evt & ~d;
    if (wr && s == 2'd2 && d[0]) m_evt[28] = 1'b1;
    for (int k = 0; k < 13; k++) if (set[k]) m_evt[19 + k] = 1'b1;
    if (wr && s == 2'd1) m_mask = d;
    check(tag, "irq_o", {19'd0, irq_o}, {19'd0, m_line});
    check(tag, "reg_rdata", reg_rdata, m_read(s));
  endtask

  task automatic idle(input logic [1:0] s, input string tag);
    step(1'b0, s, 32'h0, 13'h0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  logic [31:0] lfsr;

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R5", "irq_o in reset", {19'd0, irq_o}, 32'h0);
    check("R5", "event in reset", reg_rdata, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2'd0, "R5");
    idle(2'd1, "R5");

    // R1: each source alone, read back its bit
    for (int k = 0; k < 13; k++) step(1'b0, 2'd0, 32'h0, 13'h1 << k, "R1");
    idle(2'd0, "R1");
    // R4: enable all, lines follow one cycle later
    step(1'b1, 2'd1, 32'hFFFF_FFFF, 13'h0, "R3");
    idle(2'd1, "R4");
    idle(2'd0, "R4");
    // R2: clear alternate bits, check lines drop
    step(1'b1, 2'd0, 32'hAAAA_AAAA, 13'h0, "R2");
    idle(2'd0, "R2");
    step(1'b1, 2'd0, 32'hFFFF_FFFF, 13'h0, "R2");
    idle(2'd0, "R4");
    // R4: one line at a time through the mask
    for (int n = 0; n < 13; n++) begin
      step(1'b1, 2'd1, 32'h1 << line_src[n], 13'h1FFF, "R4");
      idle(2'd0, "R4");
      step(1'b1, 2'd0, 32'hFFFF_FFFF, 13'h0, "R4");
    end
    // R3: mask keeps low bits too
    step(1'b1, 2'd1, 32'h1234_5678, 13'h0, "R3");
    idle(2'd1, "R3");
    // R7: set and clear same cycle
    step(1'b1, 2'd1, 32'hFFF8_0000, 13'h0, "R7");
    step(1'b1, 2'd0, 32'hFFFF_FFFF, 13'h0AA5, "R7");
    idle(2'd0, "R7");
    // R6: transmit control
    step(1'b1, 2'd0, 32'hFFFF_FFFF, 13'h0, "R6");
    step(1'b1, 2'd2, 32'hFFFF_FFFE, 13'h0, "R6");
    idle(2'd0, "R6");
    step(1'b1, 2'd2, 32'h0000_0001, 13'h0, "R6");
    idle(2'd0, "R6");
    idle(2'd2, "R9");
    idle(2'd3, "R9");
    // R8: low bits never set
    step(1'b1, 2'd0, 32'h0007_FFFF, 13'h1FFF, "R8");
    idle(2'd0, "R8");
    // mixed traffic
    lfsr = 32'hACE1_1357;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step(lfsr[3], lfsr[5:4], {lfsr[31:8], lfsr[7:0] ^ lfsr[15:8]},
           (lfsr[2] ? lfsr[20:8] : 13'h0), "R9");
    end
    // R5: reset in the middle of activity
    step(1'b1, 2'd1, 32'hFFFF_FFFF, 13'h1FFF, "R5");
    idle(2'd0, "R5");
    @(negedge clk);
    reg_sel = 2'd1;
    rst_n = 1'b0;
    #1;
    check("R5", "mask after reset", reg_rdata, 32'h0);
    check("R5", "irq_o after reset", {19'd0, irq_o}, 32'h0);
    m_evt = '0; m_mask = '0; m_line = '0;
    @(negedge clk);
    rst_n = 1'b1;
    idle(2'd0, "R5");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule